// File: doc/BRIEF.md
# Bus Access Privilege Checker

This block stands between an execution core and one shared physical bus. The core hands it one request at a time, of four kinds: instruction fetch, data memory access, I/O access, or control-register access. Each request carries an address (a byte address, or for control registers a plain register index), a write flag, write data and a flag for the current privilege mode. The block judges the request before anything reaches the bus. A request that breaks a rule finishes at once with a fault and an exception code. A legal request is driven onto the bus with a kind tag, and the read data comes back to the core.

Fetch, memory and I/O transfers are 32 bits wide and need 4-byte aligned byte addresses. Control registers are reached by consecutive index and always move the full register width. I/O and control-register traffic is reserved for system mode. Fetches raise a marker line on the bus so that the rest of the system can tell code reads from data reads. The address and register width `XLEN` defaults to 64 and may be set to 32.

Top module: `bus_priv_gate`

## Requirements
- R1: After reset, `req_ready` is 1 and `bus_valid` and `rsp_done` are 0.
- R2: The kind encoding is 0 fetch, 1 memory, 2 I/O and 3 control register. An accepted legal request gives exactly one bus cycle, starting the cycle after acceptance. On that cycle `bus_kind` equals the request kind and `bus_addr` equals the request address. Both hold steady until `bus_ready` is sampled high.
- R3: `bus_fetch` is 1 only for fetch bus cycles. A fetch is always a read (`bus_write` 0), even when `req_write` is 1.
- R4: Fetch, memory and I/O cycles have `bus_wide` 0. They send only bits 31:0 of the write data, with all upper bits zero. They return bits 31:0 of `bus_rdata`, zero-extended.
- R5: Control-register cycles take any index value with no alignment rule, have `bus_wide` 1, and pass the full `XLEN` bits of data in both directions.
- R6: A fetch, memory or I/O request whose address bits 1:0 are not zero faults with code 2 (alignment), and no bus cycle is issued.
- R7: A user-mode (`req_user` 1) I/O or control-register request faults with code 1 (privilege), and no bus cycle is issued. User-mode fetch and memory requests are allowed.
- R8: When a request breaks both rules, only code 1 is reported.
- R9: A faulting request sets `rsp_done` in the cycle right after acceptance, with `rsp_fault` 1 and `rsp_rdata` zero. A successful request sets `rsp_done` the cycle after the bus handshake, with `rsp_fault` 0 and code 0.
- R10: `req_ready` is 1 only when no request is in flight. `rsp_done` is a single-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core offers a request |
| req_ready | output | 1 | Block can take a request |
| req_kind | input | 2 | 0 fetch, 1 memory, 2 I/O, 3 control register |
| req_addr | input | XLEN | Byte address, or register index for kind 3 |
| req_write | input | 1 | 1 for write |
| req_wdata | input | XLEN | Write data |
| req_user | input | 1 | 1 when the core runs in user mode |
| rsp_done | output | 1 | Request finished (one-cycle pulse) |
| rsp_fault | output | 1 | Finished with an exception |
| rsp_code | output | 2 | 0 none, 1 privilege, 2 alignment |
| rsp_rdata | output | XLEN | Read data, zero on fault |
| bus_valid | output | 1 | Bus cycle in progress |
| bus_ready | input | 1 | Bus completes the cycle |
| bus_kind | output | 2 | Kind tag of the bus cycle |
| bus_fetch | output | 1 | Instruction fetch marker |
| bus_addr | output | XLEN | Bus address or register index |
| bus_write | output | 1 | Bus write |
| bus_wide | output | 1 | 1 for a full-width transfer |
| bus_wdata | output | XLEN | Bus write data |
| bus_rdata | input | XLEN | Bus read data |

## Verification
Every kind is sent in both privilege modes. This separates the privilege rule (I/O and control registers only) from the kinds that user code may use. Misaligned addresses go to fetch, memory and I/O, and a misaligned-looking index goes to a control register, which shows that the alignment rule applies only to byte-addressed kinds. A user-mode misaligned I/O request shows the fault priority. Bus data with non-zero upper halves, together with stall lengths of one to four cycles, separates the narrow transfers from the full-width ones and shows that the bus holds its values during a stall.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
  typedef enum logic [1:0] {
    K_FETCH = 2'd0,
    K_MEM   = 2'd1,
    K_IO    = 2'd2,
    K_CTRL  = 2'd3
  } kind_t;

  typedef enum logic [1:0] {
    C_NONE  = 2'd0,
    C_PRIV  = 2'd1,
    C_ALIGN = 2'd2
  } code_t;

  localparam int unsigned NARROW_W = 32;

  // kinds reserved for system mode
  function automatic logic sys_only(kind_t k);
    return (k == K_IO) || (k == K_CTRL);
  endfunction

  // kinds that use byte addresses and 32-bit words
  function automatic logic byte_addressed(kind_t k);
    return k != K_CTRL;
  endfunction

  // privilege is judged before alignment
  function automatic code_t judge(kind_t k, logic user, logic [1:0] lo);
    if (user && sys_only(k)) return C_PRIV;
    if (byte_addressed(k) && (lo != 2'b00)) return C_ALIGN;
    return C_NONE;
  endfunction
endpackage

// File: rtl/bpg_classify.sv
module bpg_classify
  import bpg_pkg::*;
(
  input  logic [1:0] kind,
  input  logic       user,
  input  logic [1:0] addr_lo,
  output logic [1:0] code,
  output logic       fault
);
  code_t verdict;

  always_comb begin
    verdict = judge(kind_t'(kind), user, addr_lo);
    code    = verdict;
    fault   = (verdict != C_NONE);
  end
endmodule

// File: rtl/bpg_shape.sv
module bpg_shape #(
  parameter int unsigned XLEN = 64
) (
  input  logic            wide,
  input  logic [XLEN-1:0] raw,
  output logic [XLEN-1:0] shaped
);
  localparam int unsigned NW = bpg_pkg::NARROW_W;

  generate
    if (XLEN > NW) begin : g_narrow
      always_comb shaped = wide ? raw : {{(XLEN-NW){1'b0}}, raw[NW-1:0]};
    end else begin : g_same
      always_comb shaped = raw;
    end
  endgenerate
endmodule

// File: rtl/bpg_seq.sv
module bpg_seq
  import bpg_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            fault,
  input  logic [1:0]      code,
  input  logic [1:0]      kind,
  input  logic [XLEN-1:0] addr,
  input  logic            write,
  input  logic [XLEN-1:0] wdata,
  input  logic            bus_ready,
  input  logic [XLEN-1:0] rdata,
  output logic            idle,
  output logic            bus_valid,
  output logic            bus_done,
  output logic [1:0]      bus_kind,
  output logic [XLEN-1:0] bus_addr,
  output logic            bus_write,
  output logic [XLEN-1:0] bus_wdata,
  output logic            rsp_done,
  output logic            rsp_fault,
  output logic [1:0]      rsp_code,
  output logic [XLEN-1:0] rsp_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_BUS, S_RESP} st_t;
  st_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      bus_kind  <= '0;
      bus_addr  <= '0;
      bus_write <= 1'b0;
      bus_wdata <= '0;
      rsp_fault <= 1'b0;
      rsp_code  <= '0;
      rsp_rdata <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          if (fault) begin
            st        <= S_RESP;
            rsp_fault <= 1'b1;
            rsp_code  <= code;
            rsp_rdata <= '0;
          end else begin
            st        <= S_BUS;
            bus_kind  <= kind;
            bus_addr  <= addr;
            bus_write <= write && (kind_t'(kind) != K_FETCH);
            bus_wdata <= wdata;
            rsp_fault <= 1'b0;
            rsp_code  <= C_NONE;
          end
        end
        S_BUS: if (bus_ready) begin
          st        <= S_RESP;
          rsp_rdata <= rdata;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign idle      = (st == S_IDLE);
  assign bus_valid = (st == S_BUS);
  assign bus_done  = bus_valid && bus_ready;
  assign rsp_done  = (st == S_RESP);
endmodule

// File: rtl/bus_priv_gate.sv
module bus_priv_gate
  import bpg_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_kind,
  input  logic [XLEN-1:0] req_addr,
  input  logic            req_write,
  input  logic [XLEN-1:0] req_wdata,
  input  logic            req_user,
  output logic            rsp_done,
  output logic            rsp_fault,
  output logic [1:0]      rsp_code,
  output logic [XLEN-1:0] rsp_rdata,
  output logic            bus_valid,
  input  logic            bus_ready,
  output logic [1:0]      bus_kind,
  output logic            bus_fetch,
  output logic [XLEN-1:0] bus_addr,
  output logic            bus_write,
  output logic            bus_wide,
  output logic [XLEN-1:0] bus_wdata,
  input  logic [XLEN-1:0] bus_rdata
);
  // named events for the checker
  logic            evt_accept;
  logic            evt_fault;
  logic            evt_bus_done;
  logic [1:0]      judged_code;
  logic            judged_fault;
  logic            req_wide;
  logic [XLEN-1:0] wdata_cut;
  logic [XLEN-1:0] rdata_cut;

  bpg_classify u_cls (
    .kind    (req_kind),
    .user    (req_user),
    .addr_lo (req_addr[1:0]),
    .code    (judged_code),
    .fault   (judged_fault)
  );

  assign req_wide  = !byte_addressed(kind_t'(req_kind));
  assign bus_wide  = !byte_addressed(kind_t'(bus_kind));
  assign bus_fetch = bus_valid && (kind_t'(bus_kind) == K_FETCH);

  bpg_shape #(.XLEN(XLEN)) u_wshape (
    .wide   (req_wide),
    .raw    (req_wdata),
    .shaped (wdata_cut)
  );

  bpg_shape #(.XLEN(XLEN)) u_rshape (
    .wide   (bus_wide),
    .raw    (bus_rdata),
    .shaped (rdata_cut)
  );

  assign evt_accept = req_valid && req_ready;
  assign evt_fault  = evt_accept && judged_fault;

  bpg_seq #(.XLEN(XLEN)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (evt_accept),
    .fault     (judged_fault),
    .code      (judged_code),
    .kind      (req_kind),
    .addr      (req_addr),
    .write     (req_write),
    .wdata     (wdata_cut),
    .bus_ready (bus_ready),
    .rdata     (rdata_cut),
    .idle      (req_ready),
    .bus_valid (bus_valid),
    .bus_done  (evt_bus_done),
    .bus_kind  (bus_kind),
    .bus_addr  (bus_addr),
    .bus_write (bus_write),
    .bus_wdata (bus_wdata),
    .rsp_done  (rsp_done),
    .rsp_fault (rsp_fault),
    .rsp_code  (rsp_code),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: rtl/bpg_checker.sv
module bpg_checker #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            evt_accept,
  input logic            evt_fault,
  input logic            req_ready,
  input logic            req_user,
  input logic [1:0]      req_kind,
  input logic            bus_valid,
  input logic            bus_ready,
  input logic [1:0]      bus_kind,
  input logic            bus_fetch,
  input logic            bus_write,
  input logic            bus_wide,
  input logic [XLEN-1:0] bus_addr,
  input logic [XLEN-1:0] bus_wdata,
  input logic            rsp_done,
  input logic            rsp_fault,
  input logic [1:0]      rsp_code,
  input logic [XLEN-1:0] rsp_rdata
);
  assert_fault_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fault |=> rsp_done && rsp_fault && (rsp_rdata == '0));

  assert_no_bus_on_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fault |=> !bus_valid);

  assert_priv_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept && req_user && req_kind[1] |=> rsp_fault && (rsp_code == 2'd1));

  assert_fetch_readonly_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_fetch |-> !bus_write);

  assert_aligned_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && (bus_kind != 2'd3) |-> (bus_addr[1:0] == 2'b00));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_kind));

  assert_narrow_wdata_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_wide |-> ((bus_wdata >> 32) == '0));

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !req_ready);

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
endmodule

bind bus_priv_gate bpg_checker #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_accept (evt_accept),
  .evt_fault  (evt_fault),
  .req_ready  (req_ready),
  .req_user   (req_user),
  .req_kind   (req_kind),
  .bus_valid  (bus_valid),
  .bus_ready  (bus_ready),
  .bus_kind   (bus_kind),
  .bus_fetch  (bus_fetch),
  .bus_write  (bus_write),
  .bus_wide   (bus_wide),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .rsp_done   (rsp_done),
  .rsp_fault  (rsp_fault),
  .rsp_code   (rsp_code),
  .rsp_rdata  (rsp_rdata)
);

// File: tb/tb_bus_priv_gate.sv
module tb_bus_priv_gate;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [1:0]      req_kind = '0;
  logic [XLEN-1:0] req_addr = '0;
  logic            req_write = 1'b0;
  logic [XLEN-1:0] req_wdata = '0;
  logic            req_user = 1'b0;
  logic            rsp_done, rsp_fault;
  logic [1:0]      rsp_code;
  logic [XLEN-1:0] rsp_rdata;
  logic            bus_valid;
  logic            bus_ready = 1'b0;
  logic [1:0]      bus_kind;
  logic            bus_fetch, bus_write, bus_wide;
  logic [XLEN-1:0] bus_addr, bus_wdata;
  logic [XLEN-1:0] bus_rdata = '0;

  int n_checks = 0;
  int n_fail   = 0;
  bit reported = 0;

  always #5 clk = ~clk;

  bus_priv_gate #(.XLEN(XLEN)) dut (.*);

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  function automatic logic [63:0] bus_pattern(logic [63:0] a);
    return {a[31:0] ^ 32'h5A5A_0000, ~a[31:0]};
  endfunction

  // one request, reference model checked on every falling edge
  task automatic run(int kind, logic [63:0] addr, bit wr, logic [63:0] wd, bit user, int lat);
    int exp_code;
    bit wide;
    int seen;
    bit done;
    logic [63:0] exp_rd;
    wide = (kind == 3);
    if (user && (kind == 2 || kind == 3))            exp_code = 1;
    else if (kind != 3 && addr[1:0] != 2'b00)        exp_code = 2;
    else                                             exp_code = 0;
    exp_rd = (exp_code != 0) ? 64'd0 :
             (wide ? bus_pattern(addr) : {32'd0, bus_pattern(addr)[31:0]});
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready while idle", 64'(req_ready), 64'd1);
    req_valid = 1; req_kind = 2'(kind); req_addr = addr;
    req_write = wr; req_wdata = wd; req_user = user;
    seen = 0; done = 0;
    for (int cyc = 0; cyc < 40 && !done; cyc++) begin
      @(negedge clk);
      req_valid = 0;
      bus_ready = 0;
      chk(req_ready == 1'b0, "R10", "ready while busy", 64'(req_ready), 64'd0);
      if (bus_valid) begin
        seen++;
        chk(bus_kind == 2'(kind) && bus_addr == addr, "R2", "bus kind/addr",
            {bus_addr[61:0], bus_kind}, {addr[61:0], 2'(kind)});
        chk(bus_fetch == (kind == 0), "R3", "fetch marker", 64'(bus_fetch), 64'(kind == 0));
        chk(bus_write == (wr && kind != 0), "R3", "write flag", 64'(bus_write), 64'(wr && kind != 0));
        chk(bus_wide == wide, wide ? "R5" : "R4", "wide flag", 64'(bus_wide), 64'(wide));
        chk(bus_wdata == (wide ? wd : {32'd0, wd[31:0]}), wide ? "R5" : "R4", "write data",
            bus_wdata, wide ? wd : {32'd0, wd[31:0]});
        if (seen >= lat) begin
          bus_ready = 1;
          bus_rdata = bus_pattern(addr);
        end
      end
      if (rsp_done) begin
        done = 1;
        chk(rsp_fault == (exp_code != 0), "R9", "fault flag", 64'(rsp_fault), 64'(exp_code != 0));
        chk(rsp_code == 2'(exp_code), exp_code == 1 ? "R7" : (exp_code == 2 ? "R6" : "R9"),
            "code", 64'(rsp_code), 64'(exp_code));
        chk(rsp_rdata == exp_rd, wide ? "R5" : "R4", "read data", rsp_rdata, exp_rd);
        chk(seen == ((exp_code != 0) ? 0 : lat), "R2", "bus cycles", 64'(seen),
            64'((exp_code != 0) ? 0 : lat));
        if (exp_code != 0)
          chk(cyc == 0, "R9", "fault latency", 64'(cyc), 64'd0);
      end
    end
    if (!done) chk(1'b0, "R10", "no completion", 64'd0, 64'd1);
    @(negedge clk);
    bus_ready = 0;
    chk(rsp_done == 1'b0, "R10", "done pulse width", 64'(rsp_done), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && bus_valid == 0 && rsp_done == 0, "R1", "reset state",
        {61'd0, req_ready, bus_valid, rsp_done}, 64'b100);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && bus_valid == 0 && rsp_done == 0, "R1", "after reset",
        {61'd0, req_ready, bus_valid, rsp_done}, 64'b100);
    run(0, 64'h0000_0000_0000_1000, 1, 64'h1111_2222_3333_4444, 1, 1); // R3 user fetch, write ignored
    run(1, 64'h0000_0004_0000_2008, 1, 64'hDEAD_BEEF_1234_5678, 0, 3); // R4 memory write
    run(1, 64'h0000_0000_0000_3010, 0, 64'd0, 1, 2);                   // R7 user memory allowed
    run(2, 64'h0000_0000_F000_0004, 1, 64'hCAFE_F00D_0000_00AA, 0, 4); // R4 I/O system
    run(3, 64'h0000_0000_0000_0007, 1, 64'hFEDC_BA98_7654_3210, 0, 2); // R5 control index
    run(3, 64'h0000_0000_0000_0002, 0, 64'd0, 0, 1);                   // R5 control read
    run(3, 64'h0000_0000_0000_0004, 0, 64'd0, 1, 1);                   // R7 user control
    run(2, 64'h0000_0000_F000_0008, 0, 64'd0, 1, 1);                   // R7 user I/O
    run(1, 64'h0000_0000_0000_1002, 1, 64'h55, 0, 1);                  // R6 memory misaligned
    run(0, 64'h0000_0000_0000_2001, 0, 64'd0, 1, 1);                   // R6 fetch misaligned
    run(2, 64'h0000_0000_F000_0003, 0, 64'd0, 0, 1);                   // R6 I/O misaligned
    run(2, 64'h0000_0000_F000_0003, 0, 64'd0, 1, 1);                   // R8 both rules broken
    run(0, 64'h8000_0000_0000_0100, 0, 64'd0, 0, 4);                   // R2 long stall fetch
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R10", "watchdog expired", 64'd0, 64'd1);
    report();
  end
endmodule